// File: doc/BRIEF.md
# Encoded Microoperation Field Executor

This block carries out the register-transfer part of a microinstruction. Each control word gives it three 3-bit fields. Each field is decoded on its own into a small group of mutually exclusive transfers. The block holds a 16-bit accumulator, a 16-bit data register, an 11-bit address register and an 11-bit program counter. When the valid strobe is high, every transfer selected by the three fields takes effect on the same rising clock edge.

Storage sits outside the block. The block presents a 2048-word by 16-bit memory port. The address register drives the word address and the data register drives the write data. The read data must be valid combinationally in the same cycle as the read strobe. The block also returns three status bits that a microprogram sequencer can test for branching.

Top module: `uop_field_exec`

## Requirements
- R1: While `rstN` is low, all four registers are cleared to zero.
- R2: While `uopValid` is low, no register changes and `memWrEn` and `memRdEn` stay low, whatever the three fields hold.
- R3: Field A codes: 0 does nothing, 1 adds the data register to the accumulator, 2 clears the accumulator, 3 increments the accumulator, 4 copies the data register into the accumulator, 5 loads the address register from the data register's low 11 bits, 6 loads the address register from the program counter, and 7 writes the data register to memory.
- R4: Field B codes: 0 does nothing, 1 sets the accumulator to itself minus the data register, 2 ORs the data register into the accumulator, 3 ANDs the data register into the accumulator, 4 loads the data register from memory, 5 copies the accumulator into the data register, 6 increments the data register, and 7 loads the program counter into the data register's low 11 bits.
- R5: Field C codes: 0 does nothing, 1 XORs the data register into the accumulator, 2 inverts the accumulator, 3 shifts the accumulator left by one, 4 shifts it right by one, 5 increments the program counter, 6 loads the program counter from the address register, and 7 does nothing.
- R6: `memAddr` always shows the address register and `memWrData` always shows the data register. `memWrEn` is high exactly when the operation is valid and field A is 7. `memRdEn` is high exactly when the operation is valid and field B is 4. In that case, the data register takes `memRdData` on the edge.
- R7: All transfers in one microinstruction take effect on the same edge, and every one of them reads the register values from before that edge.
- R8: Both shifts bring in a zero bit. Additions, subtractions and increments wrap modulo the register width.
- R9: When the data register takes the program counter, its upper 5 bits keep their previous value.
- R10: When several fields write the accumulator in one cycle, the result from field C is used over the result from field B, and the result from field B is used over the result from field A.
- R11: `dataSign` is bit 15 of the data register, `accSign` is bit 15 of the accumulator, and `accZero` is high exactly when the accumulator is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| uopValid | input | 1 | Applies the three fields on this edge |
| fieldA | input | 3 | First microoperation field |
| fieldB | input | 3 | Second microoperation field |
| fieldC | input | 3 | Third microoperation field |
| memRdData | input | 16 | Word read at `memAddr`, valid in the same cycle |
| memAddr | output | 11 | Memory word address (address register) |
| memWrData | output | 16 | Memory write data (data register) |
| memWrEn | output | 1 | Memory write strobe |
| memRdEn | output | 1 | Memory read strobe |
| accOut | output | 16 | Accumulator |
| dataOut | output | 16 | Data register |
| addrOut | output | 11 | Address register |
| pcOut | output | 11 | Program counter |
| dataSign | output | 1 | Data register bit 15 |
| accSign | output | 1 | Accumulator bit 15 |
| accZero | output | 1 | Accumulator equals zero |

## Verification
The bench targets microinstructions whose fields feed one another. A memory read combined with a copy from the data register to the accumulator, and a swap of the accumulator and the data register, would expose a design that chained values through within one cycle instead of using the values from before the edge. Microinstructions in which two or three fields write the accumulator would reveal a wrong priority. Shifting a lone top or bottom bit, and incrementing all-ones, would show a design that rotated instead of shifting or failed to wrap. Copying the program counter into a data register that holds all ones would show a design that cleared the upper bits. Idle cycles with write and read codes on the fields would catch strobes that ignore the valid signal.

// File: rtl/uop_exec_pkg.sv
package uop_exec_pkg;
  localparam int FIELD_W = 3;

  // Field A strobe indices
  localparam int A_ADD  = 1;
  localparam int A_CLR  = 2;
  localparam int A_INC  = 3;
  localparam int A_LDDR = 4;
  localparam int A_ARDR = 5;
  localparam int A_ARPC = 6;
  localparam int A_WR   = 7;

  // Field B strobe indices
  localparam int B_SUB  = 1;
  localparam int B_OR   = 2;
  localparam int B_AND  = 3;
  localparam int B_RD   = 4;
  localparam int B_ACC  = 5;
  localparam int B_INC  = 6;
  localparam int B_PC   = 7;

  // Field C strobe indices (code 7 is reserved and produces no strobe)
  localparam int C_XOR   = 1;
  localparam int C_NOT   = 2;
  localparam int C_SHL   = 3;
  localparam int C_SHR   = 4;
  localparam int C_PCINC = 5;
  localparam int C_PCAR  = 6;
  localparam int C_LAST  = 6;

  typedef struct packed {
    logic [7:1]      a;
    logic [7:1]      b;
    logic [C_LAST:1] c;
  } uop_strobe_t;
endpackage

// File: rtl/uop_field_dec.sv
module uop_field_dec
  import uop_exec_pkg::*;
#(
  parameter int HI = 7
) (
  input  logic               en,
  input  logic [FIELD_W-1:0] code,
  output logic [HI:1]        hot
);
  for (genvar i = 1; i <= HI; i++) begin : g_out
    assign hot[i] = en && (code == FIELD_W'(i));
  end
endmodule

// File: rtl/uop_ctrl.sv
module uop_ctrl
  import uop_exec_pkg::*;
(
  input  logic               uopValid,
  input  logic [FIELD_W-1:0] fieldA,
  input  logic [FIELD_W-1:0] fieldB,
  input  logic [FIELD_W-1:0] fieldC,
  output uop_strobe_t        stb
);
  logic [7:1]      hotA;
  logic [7:1]      hotB;
  logic [C_LAST:1] hotC;

  uop_field_dec #(.HI(7))      decA (.en(uopValid), .code(fieldA), .hot(hotA));
  uop_field_dec #(.HI(7))      decB (.en(uopValid), .code(fieldB), .hot(hotB));
  uop_field_dec #(.HI(C_LAST)) decC (.en(uopValid), .code(fieldC), .hot(hotC));

  assign stb.a = hotA;
  assign stb.b = hotB;
  assign stb.c = hotC;
endmodule

// File: rtl/uop_datapath.sv
module uop_datapath
  import uop_exec_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  uop_strobe_t       stb,
  input  logic [DATA_W-1:0] memRdData,
  output logic              memWrEn,
  output logic              memRdEn,
  output logic [DATA_W-1:0] acc,
  output logic [DATA_W-1:0] dr,
  output logic [ADDR_W-1:0] ar,
  output logic [ADDR_W-1:0] pc
);
  localparam int HIGH_W = DATA_W - ADDR_W;

  logic [DATA_W-1:0] accNext;
  logic [DATA_W-1:0] drNext;
  logic [ADDR_W-1:0] arNext;
  logic [ADDR_W-1:0] pcNext;

  // Later fields overwrite earlier ones, giving C over B over A
  always_comb begin
    accNext = acc;
    if (stb.a[A_ADD])       accNext = acc + dr;
    else if (stb.a[A_CLR])  accNext = '0;
    else if (stb.a[A_INC])  accNext = acc + 1'b1;
    else if (stb.a[A_LDDR]) accNext = dr;

    if (stb.b[B_SUB])       accNext = acc - dr;
    else if (stb.b[B_OR])   accNext = acc | dr;
    else if (stb.b[B_AND])  accNext = acc & dr;

    if (stb.c[C_XOR])       accNext = acc ^ dr;
    else if (stb.c[C_NOT])  accNext = ~acc;
    else if (stb.c[C_SHL])  accNext = {acc[DATA_W-2:0], 1'b0};
    else if (stb.c[C_SHR])  accNext = {1'b0, acc[DATA_W-1:1]};
  end

  always_comb begin
    drNext = dr;
    if (stb.b[B_RD])        drNext = memRdData;
    else if (stb.b[B_ACC])  drNext = acc;
    else if (stb.b[B_INC])  drNext = dr + 1'b1;
    else if (stb.b[B_PC])   drNext = {dr[DATA_W-1 -: HIGH_W], pc};
  end

  always_comb begin
    arNext = ar;
    if (stb.a[A_ARDR])      arNext = dr[ADDR_W-1:0];
    else if (stb.a[A_ARPC]) arNext = pc;
  end

  always_comb begin
    pcNext = pc;
    if (stb.c[C_PCINC])     pcNext = pc + 1'b1;
    else if (stb.c[C_PCAR]) pcNext = ar;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc <= '0;
      dr  <= '0;
      ar  <= '0;
      pc  <= '0;
    end else begin
      acc <= accNext;
      dr  <= drNext;
      ar  <= arNext;
      pc  <= pcNext;
    end
  end

  assign memWrEn = stb.a[A_WR];
  assign memRdEn = stb.b[B_RD];
endmodule

// File: rtl/uop_field_exec.sv
module uop_field_exec
  import uop_exec_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 11
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               uopValid,
  input  logic [FIELD_W-1:0] fieldA,
  input  logic [FIELD_W-1:0] fieldB,
  input  logic [FIELD_W-1:0] fieldC,
  input  logic [DATA_W-1:0]  memRdData,
  output logic [ADDR_W-1:0]  memAddr,
  output logic [DATA_W-1:0]  memWrData,
  output logic               memWrEn,
  output logic               memRdEn,
  output logic [DATA_W-1:0]  accOut,
  output logic [DATA_W-1:0]  dataOut,
  output logic [ADDR_W-1:0]  addrOut,
  output logic [ADDR_W-1:0]  pcOut,
  output logic               dataSign,
  output logic               accSign,
  output logic               accZero
);
  uop_strobe_t stb;

  uop_ctrl ctrlI (
    .uopValid(uopValid), .fieldA(fieldA), .fieldB(fieldB), .fieldC(fieldC), .stb(stb)
  );

  uop_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dpI (
    .clk(clk), .rstN(rstN), .stb(stb), .memRdData(memRdData),
    .memWrEn(memWrEn), .memRdEn(memRdEn),
    .acc(accOut), .dr(dataOut), .ar(addrOut), .pc(pcOut)
  );

  assign memAddr   = addrOut;
  assign memWrData = dataOut;
  assign dataSign  = dataOut[DATA_W-1];
  assign accSign   = accOut[DATA_W-1];
  assign accZero   = (accOut == '0);
endmodule

// File: rtl/uop_field_exec_chk.sv
module uop_field_exec_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rstN,
  input logic              uopValid,
  input logic [2:0]        fieldA,
  input logic [2:0]        fieldB,
  input logic [2:0]        fieldC,
  input logic              memWrEn,
  input logic              memRdEn,
  input logic [DATA_W-1:0] accOut,
  input logic [DATA_W-1:0] dataOut,
  input logic [ADDR_W-1:0] addrOut,
  input logic [ADDR_W-1:0] pcOut,
  input logic              accZero
);
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !uopValid |=> $stable(accOut) && $stable(dataOut) && $stable(addrOut) && $stable(pcOut));

  // R6
  wr_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> uopValid && fieldA == 3'd7);

  // R6
  rd_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> uopValid && fieldB == 3'd4);

  // R5
  pc_inc_chk: assert property (@(posedge clk) disable iff (!rstN)
    uopValid && fieldC == 3'd5 |=> pcOut == $past(pcOut) + 1'b1);

  // R3
  ar_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(uopValid && (fieldA == 3'd5 || fieldA == 3'd6)) |=> $stable(addrOut));

  // R11
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    uopValid && fieldA == 3'd2 && fieldB == 3'd0 && fieldC == 3'd0 |=> accZero);

  // R9
  dr_high_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    uopValid && fieldB == 3'd7 |=> dataOut[DATA_W-1:ADDR_W] == $past(dataOut[DATA_W-1:ADDR_W]));
endmodule

bind uop_field_exec uop_field_exec_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chkI (.*);

// File: tb/uop_field_exec_test.sv
`timescale 1ns/1ps
module uop_field_exec_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        uopValid = 1'b0;
  logic [2:0]  fieldA = '0, fieldB = '0, fieldC = '0;
  logic [15:0] memRdData;
  logic [10:0] memAddr;
  logic [15:0] memWrData;
  logic        memWrEn, memRdEn;
  logic [15:0] accOut, dataOut;
  logic [10:0] addrOut, pcOut;
  logic        dataSign, accSign, accZero;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [15:0] mem [0:2047];
  logic [15:0] mAc, mDr;
  logic [10:0] mAr, mPc;

  always #2.5 clk = ~clk;

  uop_field_exec uut (.*);

  assign memRdData = mem[memAddr];
  always @(posedge clk) if (rstN && memWrEn) mem[memAddr] <= memWrData;

  task automatic cmp(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic cmpRegs(input string tag);
    cmp(tag, "acc", accOut, mAc);
    cmp(tag, "dr", dataOut, mDr);
    cmp(tag, "ar", 16'(addrOut), 16'(mAr));
    cmp(tag, "pc", 16'(pcOut), 16'(mPc));
    cmp("R11", "dataSign", 16'(dataSign), 16'(mDr[15]));
    cmp("R11", "accSign", 16'(accSign), 16'(mAc[15]));
    cmp("R11", "accZero", 16'(accZero), 16'(mAc == 16'h0));
  endtask

  // Called just after a falling edge; returns just after the next falling edge
  task automatic doOp(input string tag, input bit v, input logic [2:0] a, input logic [2:0] b, input logic [2:0] c);
    logic [15:0] nAc, nDr, rd;
    logic [10:0] nAr, nPc;
    uopValid = v; fieldA = a; fieldB = b; fieldC = c;
    #1;
    cmp("R6", "memWrEn", 16'(memWrEn), 16'(v && a == 3'd7));
    cmp("R6", "memRdEn", 16'(memRdEn), 16'(v && b == 3'd4));
    cmp("R6", "memAddr", 16'(memAddr), 16'(mAr));
    cmp("R6", "memWrData", memWrData, mDr);
    rd = mem[mAr];
    nAc = mAc; nDr = mDr; nAr = mAr; nPc = mPc;
    if (v) begin
      case (a)
        3'd1: nAc = mAc + mDr;
        3'd2: nAc = 16'h0;
        3'd3: nAc = mAc + 16'h1;
        3'd4: nAc = mDr;
        3'd5: nAr = mDr[10:0];
        3'd6: nAr = mPc;
        default: ;
      endcase
      case (b)
        3'd1: nAc = mAc - mDr;
        3'd2: nAc = mAc | mDr;
        3'd3: nAc = mAc & mDr;
        3'd4: nDr = rd;
        3'd5: nDr = mAc;
        3'd6: nDr = mDr + 16'h1;
        3'd7: nDr = {mDr[15:11], mPc};
        default: ;
      endcase
      case (c)
        3'd1: nAc = mAc ^ mDr;
        3'd2: nAc = ~mAc;
        3'd3: nAc = mAc << 1;
        3'd4: nAc = mAc >> 1;
        3'd5: nPc = mPc + 11'h1;
        3'd6: nPc = mAr;
        default: ;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    mAc = nAc; mDr = nDr; mAr = nAr; mPc = nPc;
    cmpRegs(tag);
  endtask

  initial begin
    for (int i = 0; i < 2048; i++) mem[i] = 16'(i * 16'h1357) ^ 16'hA5C3;
    mem[0] = 16'h8000;
    mem[1] = 16'h0001;
    mem[2] = 16'hFFFF;
    mAc = '0; mDr = '0; mAr = '0; mPc = '0;
    repeat (3) @(negedge clk);
    cmpRegs("R1");
    rstN = 1'b1;

    doOp("R2", 0, 3'd7, 3'd4, 3'd5);     // idle with write/read/inc codes
    doOp("R4", 1, 3'd0, 3'd4, 3'd0);     // DR <- mem[0] = 8000
    doOp("R3", 1, 3'd4, 3'd0, 3'd0);     // AC <- DR
    doOp("R8", 1, 3'd0, 3'd0, 3'd3);     // shl 8000 -> 0
    doOp("R5", 1, 3'd0, 3'd0, 3'd5);     // PC = 1
    doOp("R3", 1, 3'd6, 3'd0, 3'd0);     // AR <- PC
    doOp("R6", 1, 3'd0, 3'd4, 3'd0);     // DR <- mem[1] = 0001
    doOp("R3", 1, 3'd4, 3'd0, 3'd0);
    doOp("R8", 1, 3'd0, 3'd0, 3'd4);     // shr 0001 -> 0
    doOp("R7", 1, 3'd6, 3'd0, 3'd5);     // AR <- old PC, PC++
    doOp("R3", 1, 3'd6, 3'd0, 3'd0);     // AR = 2
    doOp("R6", 1, 3'd0, 3'd4, 3'd0);     // DR = FFFF
    doOp("R3", 1, 3'd4, 3'd0, 3'd0);
    doOp("R8", 1, 3'd3, 3'd0, 3'd0);     // FFFF + 1 wraps to 0
    doOp("R9", 1, 3'd0, 3'd7, 3'd0);     // DR = F800 | PC
    doOp("R3", 1, 3'd4, 3'd0, 3'd0);
    doOp("R3", 1, 3'd1, 3'd0, 3'd0);
    doOp("R4", 1, 3'd0, 3'd1, 3'd0);
    doOp("R4", 1, 3'd0, 3'd2, 3'd0);
    doOp("R4", 1, 3'd0, 3'd3, 3'd0);
    doOp("R5", 1, 3'd0, 3'd0, 3'd1);
    doOp("R5", 1, 3'd0, 3'd0, 3'd2);
    doOp("R3", 1, 3'd5, 3'd0, 3'd0);     // AR <- DR low bits
    doOp("R4", 1, 3'd0, 3'd5, 3'd0);     // DR <- AC
    doOp("R6", 1, 3'd7, 3'd0, 3'd0);     // write
    doOp("R6", 1, 3'd0, 3'd4, 3'd0);     // read it back
    doOp("R4", 1, 3'd0, 3'd6, 3'd0);
    doOp("R5", 1, 3'd0, 3'd0, 3'd6);     // PC <- AR
    doOp("R5", 1, 3'd0, 3'd0, 3'd7);     // reserved
    doOp("R7", 1, 3'd4, 3'd5, 3'd0);     // swap AC and DR
    doOp("R7", 1, 3'd4, 3'd4, 3'd0);     // AC gets old DR while DR reads
    doOp("R10", 1, 3'd3, 3'd1, 3'd2);    // field C wins
    doOp("R10", 1, 3'd1, 3'd2, 3'd0);    // field B wins
    doOp("R10", 1, 3'd2, 3'd0, 3'd4);
    doOp("R2", 0, 3'd7, 3'd6, 3'd6);
    doOp("R11", 1, 3'd2, 3'd0, 3'd0);
    for (int n = 0; n < 400; n++)
      doOp("R7", ($urandom_range(0, 7) != 0), 3'($urandom), 3'($urandom), 3'($urandom));
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule